// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point numbers in the IEEE 754 single format. A subtract request flips the sign of the second operand. The two operands are then ordered by magnitude. The larger one supplies the tentative exponent and the sign of the result. The smaller significand is shifted right by the exponent gap into a 27-bit working field. That field holds the 24 significand bits, two bits that were shifted out, and one bit that records whether anything further down was lost. A single magnitude adder/subtractor combines the two fields. Its output is normalized either by one place to the right after a carry, or to the left by the leading-zero count. It is then rounded to nearest with ties to even, and normalized a second time if the rounding increment carries out.

An operation is launched by presenting both operands and the subtract select with `in_valid` high. The result and four exception flags appear on the registered outputs one clock later, together with `out_valid`. Operations may be issued on every cycle. Subnormal inputs count as zero. Results too small to be normal are replaced by zero. Infinities and NaNs are handled ahead of the arithmetic path.

Top module: `fp32_addsub`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `sum_out` and all four flags are 0. Each `in_valid` cycle yields `out_valid` high with its result on the next clock edge. A cycle without `in_valid` yields `out_valid` low on the next edge, and the output word holds its value.
- R2: For finite normal operands, `sum_out` equals A+B when `do_sub`=0 and A−B when `do_sub`=1, rounded to nearest with ties to even. The word is {sign bit 31, biased exponent bits 30:23, fraction bits 22:0}, with bias 127.
- R3: The operand of smaller magnitude is aligned by the exponent gap. Bits shifted out below the guard and round positions still decide rounding. Any gap of 27 or more leaves only that lost-bits indication, so for example 1.0 + 2^-30 gives 1.0.
- R4: A carry out of an effective addition increments the exponent. A rounding increment that carries past the top significand bit gives the next power of two, for example 0x3F7FFFFF + 0x33000000 = 0x3F800000.
- R5: An effective subtraction is normalized by its leading-zero count, for example 1.0 − 0x3F7FFFFF = 0x33800000 exactly. Every zero result, including exact cancellation, is +0 (0x00000000).
- R6: A result exactly halfway between two representable values goes to the one with an even fraction LSB.
- R7: An operand with exponent field 0 is treated as zero. A nonzero result of magnitude below 2^-126 is replaced by +0 with `flg_underflow` and `flg_inexact` set.
- R8: A rounded result with biased exponent of 255 or more gives infinity carrying the result sign (exponent all ones, fraction 0), with `flg_overflow` and `flg_inexact` set.
- R9: If either operand is a NaN (exponent all ones, fraction nonzero), or infinities of opposite effective sign meet, the result is the quiet NaN 0x7FC00000. `flg_invalid` is set for the infinity case and for a signalling NaN operand (fraction bit 22 clear), and not for a quiet NaN operand.
- R10: An infinite operand combined with a finite one, or with an infinity of the same effective sign, gives that infinity with its effective sign and no flags.
- R11: `flg_inexact` is set exactly when the delivered finite result differs from the exact sum. At most one of `flg_invalid`, `flg_overflow` and `flg_underflow` is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Launches an operation on the operands present |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| do_sub | input | 1 | 1 selects A−B, 0 selects A+B |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| sum_out | output | 32 | Rounded result |
| flg_invalid | output | 1 | Invalid operation |
| flg_overflow | output | 1 | Result overflowed to infinity |
| flg_underflow | output | 1 | Result flushed to zero |
| flg_inexact | output | 1 | Result differs from the exact sum |

## Verification
The bench sweeps every exponent gap from 0 to 40 in both operand orders, with sign and operation combinations, across fraction patterns chosen to produce carries, borrows and runs of ones. A shifter that drops the lost-bits indication would round these cases down wrongly, and one that mishandles gaps past the field width would corrupt the smaller operand. Directed cases cover the halfway ties, which a round-half-up design would bump to the odd neighbour, and the rounding carry, which an adder without a second normalization would wrap to a wrong fraction. They also cover exact cancellation, where a missing zero path gives −0 or garbage, and overflow created by rounding alone, which is missed if the exponent is tested before rounding. Random vectors, including near-cancelling pairs and special encodings, are compared with a real-number reference that rounds independently.

// File: rtl/fpas_pkg.sv
// Shared types for the floating-point adder/subtractor.
// Assumes nothing beyond being compiled before the modules that import it.
package fpas_pkg;

    // Exception flags delivered with each result
    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } fpas_flags_t;

    // Which kind of word the result selector emits
    typedef enum logic [1:0] {
        OUT_NUM  = 2'd0,
        OUT_QNAN = 2'd1,
        OUT_INF  = 2'd2,
        OUT_ZERO = 2'd3
    } fpas_out_t;

endpackage

// File: rtl/fpas_rshift_sticky.sv
// Logarithmic right shifter that also reports whether any set bit was
// shifted out. Each stage handles one bit of the shift amount. A stage
// whose distance reaches the full width clears the data, so shift amounts
// larger than the width are safe.
module fpas_rshift_sticky #(
    parameter int W    = 26,
    parameter int SH_W = 8
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout,
    output logic            sticky
);

    logic [SH_W:0][W-1:0] stg;
    logic [SH_W:0]        stk;

    assign stg[0] = din;
    assign stk[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < SH_W; k++) begin : g_stage
            localparam longint DIST = 64'd1 << k;
            if (DIST >= W) begin : g_wide
                // Stage wider than the field: everything leaves
                assign stg[k+1] = amt[k] ? '0 : stg[k];
                assign stk[k+1] = stk[k] | (amt[k] & (|stg[k]));
            end else begin : g_narrow
                // Stage shifts by DIST and collects the departing bits
                assign stg[k+1] = amt[k] ? (stg[k] >> DIST) : stg[k];
                assign stk[k+1] = stk[k] | (amt[k] & (|stg[k][DIST-1:0]));
            end
        end
    endgenerate

    assign dout   = stg[SH_W];
    assign sticky = stk[SH_W];

endmodule

// File: rtl/fpas_lzc.sv
// Leading-zero counter. An all-zero input reports W.
module fpas_lzc #(
    parameter int W  = 27,
    parameter int CW = 5
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    // Priority scan from the most significant bit
    always_comb begin
        logic found;
        found = 1'b0;
        cnt   = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                cnt   = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpas_norm_round.sv
// Normalizes the raw magnitude sum and rounds it to nearest-even.
// Input: a sum of EXT_W+1 bits whose top bit is the adder carry.
// EXT_W = significand + guard + round + sticky. Also takes the tentative
// biased exponent. Output: a signed exponent (may be out of range, so the
// caller decides overflow/underflow), the fraction, a zero indication and
// whether bits were discarded.
module fpas_norm_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W+4:0]         raw_sum,
    input  logic [EXP_W-1:0]          exp_in,
    output logic signed [EXP_W+1:0]   exp_out,
    output logic [FRAC_W-1:0]         frac_out,
    output logic                      sum_zero,
    output logic                      inexact
);

    localparam int SIG_W = FRAC_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int CNT_W = $clog2(EXT_W + 1);
    localparam int SE_W  = EXP_W + 2;

    logic [CNT_W-1:0]       lz;
    logic [EXT_W-1:0]       nrm;
    logic signed [SE_W-1:0] e_nrm;
    logic [SIG_W-1:0]       mant;
    logic                   rbit;
    logic                   sbit;
    logic                   rnd_up;
    logic [SIG_W:0]         m_rnd;

    fpas_lzc #(.W(EXT_W), .CW(CNT_W)) u_lzc (
        .vec (raw_sum[EXT_W-1:0]),
        .cnt (lz)
    );

    // First normalization: one place right on carry, else left by lz
    always_comb begin
        if (raw_sum[EXT_W]) begin
            nrm   = {raw_sum[EXT_W:2], raw_sum[1] | raw_sum[0]};
            e_nrm = $signed({2'b00, exp_in}) + SE_W'(1);
        end else begin
            nrm   = raw_sum[EXT_W-1:0] << lz;
            e_nrm = $signed({2'b00, exp_in}) - $signed({{(SE_W-CNT_W){1'b0}}, lz});
        end
    end

    // Round to nearest-even and renormalize on a rounding carry
    always_comb begin
        mant   = nrm[EXT_W-1 -: SIG_W];
        rbit   = nrm[2];
        sbit   = |nrm[1:0];
        rnd_up = rbit & (mant[0] | sbit);
        m_rnd  = {1'b0, mant} + {{SIG_W{1'b0}}, rnd_up};
        if (m_rnd[SIG_W]) begin
            frac_out = m_rnd[SIG_W-1:1];
            exp_out  = e_nrm + SE_W'(1);
        end else begin
            frac_out = m_rnd[FRAC_W-1:0];
            exp_out  = e_nrm;
        end
        inexact = rbit | sbit;
    end

    assign sum_zero = (raw_sum == '0);

endmodule

// File: rtl/fp32_addsub.sv
// Floating-point adder/subtractor with a one-cycle registered result.
// Input handling: decodes both operands, folds the subtract select into
// the second sign, orders by magnitude, aligns the smaller significand with
// guard/round/sticky, and adds or subtracts magnitudes. The result is then
// normalized and rounded. Specials are resolved by a final selector.
// Assumes: exponent field 0 means zero (subnormals flushed); every zero
// result is +0; a NaN result is the canonical quiet NaN.
module fp32_addsub #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXP_W+FRAC_W:0]     opnd_a,
    input  logic [EXP_W+FRAC_W:0]     opnd_b,
    input  logic                      do_sub,
    output logic                      out_valid,
    output logic [EXP_W+FRAC_W:0]     sum_out,
    output logic                      flg_invalid,
    output logic                      flg_overflow,
    output logic                      flg_underflow,
    output logic                      flg_inexact
);

    import fpas_pkg::*;

    localparam int W       = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int ALN_W   = SIG_W + 2;
    localparam int EXT_W   = SIG_W + 3;
    localparam int SE_W    = EXP_W + 2;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    // Decoded operand fields, index 0 = A, index 1 = B with effective sign
    logic [1:0][W-1:0]      raw;
    logic [1:0]             op_sign;
    logic [1:0][EXP_W-1:0]  op_exp;
    logic [1:0][FRAC_W-1:0] op_frac;
    logic [1:0]             op_zero;
    logic [1:0]             op_inf;
    logic [1:0]             op_nan;
    logic [1:0]             op_snan;
    logic [1:0][W-2:0]      op_mag;

    assign raw[0] = opnd_a;
    assign raw[1] = {opnd_b[W-1] ^ do_sub, opnd_b[W-2:0]};

    genvar i;
    generate
        for (i = 0; i < 2; i++) begin : g_unpack
            assign op_sign[i] = raw[i][W-1];
            assign op_exp[i]  = raw[i][W-2:FRAC_W];
            assign op_frac[i] = raw[i][FRAC_W-1:0];
            assign op_zero[i] = (op_exp[i] == '0);
            assign op_inf[i]  = (op_exp[i] == EXP_W'(EXP_MAX)) && (op_frac[i] == '0);
            assign op_nan[i]  = (op_exp[i] == EXP_W'(EXP_MAX)) && (op_frac[i] != '0);
            assign op_snan[i] = op_nan[i] && !op_frac[i][FRAC_W-1];
            assign op_mag[i]  = op_zero[i] ? '0 : raw[i][W-2:0];
        end
    endgenerate

    // Magnitude ordering and alignment
    logic              big_sel;
    logic [EXP_W-1:0]  e_big;
    logic [EXP_W-1:0]  e_gap;
    logic [SIG_W-1:0]  sig_big;
    logic [SIG_W-1:0]  sig_small;
    logic [ALN_W-1:0]  aligned;
    logic              aln_sticky;
    logic              res_sign;
    logic              eff_sub;
    logic [EXT_W:0]    raw_sum;

    // Choose the larger magnitude (B only when strictly larger)
    always_comb begin
        big_sel   = (op_mag[1] > op_mag[0]);
        e_big     = op_exp[big_sel];
        e_gap     = op_exp[big_sel] - op_exp[!big_sel];
        sig_big   = op_zero[big_sel]  ? '0 : {1'b1, op_frac[big_sel]};
        sig_small = op_zero[!big_sel] ? '0 : {1'b1, op_frac[!big_sel]};
        res_sign  = op_sign[big_sel];
        eff_sub   = op_sign[0] ^ op_sign[1];
    end

    fpas_rshift_sticky #(.W(ALN_W), .SH_W(EXP_W)) u_align (
        .din    ({sig_small, 2'b00}),
        .amt    (e_gap),
        .dout   (aligned),
        .sticky (aln_sticky)
    );

    // Magnitude add or subtract; larger minus smaller never borrows
    always_comb begin
        if (eff_sub)
            raw_sum = {1'b0, sig_big, 3'b000} - {1'b0, aligned, aln_sticky};
        else
            raw_sum = {1'b0, sig_big, 3'b000} + {1'b0, aligned, aln_sticky};
    end

    logic signed [SE_W-1:0] nr_exp;
    logic [FRAC_W-1:0]      nr_frac;
    logic                   nr_zero;
    logic                   nr_inexact;

    fpas_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
        .raw_sum  (raw_sum),
        .exp_in   (e_big),
        .exp_out  (nr_exp),
        .frac_out (nr_frac),
        .sum_zero (nr_zero),
        .inexact  (nr_inexact)
    );

    // Result selection covering specials and range limits
    fpas_out_t   kind;
    logic        kind_sign;
    fpas_flags_t nxt_flags;
    logic [W-1:0] nxt_word;

    always_comb begin
        nxt_flags = '0;
        kind_sign = res_sign;
        if (op_nan[0] || op_nan[1]) begin
            kind              = OUT_QNAN;
            nxt_flags.invalid = op_snan[0] | op_snan[1];
        end else if (op_inf[0] && op_inf[1] && eff_sub) begin
            kind              = OUT_QNAN;
            nxt_flags.invalid = 1'b1;
        end else if (op_inf[0]) begin
            kind      = OUT_INF;
            kind_sign = op_sign[0];
        end else if (op_inf[1]) begin
            kind      = OUT_INF;
            kind_sign = op_sign[1];
        end else if (nr_zero) begin
            kind = OUT_ZERO;
        end else if (nr_exp >= SE_W'(EXP_MAX)) begin
            kind               = OUT_INF;
            nxt_flags.overflow = 1'b1;
            nxt_flags.inexact  = 1'b1;
        end else if (nr_exp <= SE_W'(0)) begin
            kind                = OUT_ZERO;
            nxt_flags.underflow = 1'b1;
            nxt_flags.inexact   = 1'b1;
        end else begin
            kind              = OUT_NUM;
            nxt_flags.inexact = nr_inexact;
        end
    end

    // Assemble the output word for the selected kind
    always_comb begin
        unique case (kind)
            OUT_QNAN: nxt_word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
            OUT_INF:  nxt_word = {kind_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            OUT_ZERO: nxt_word = '0;
            default:  nxt_word = {res_sign, nr_exp[EXP_W-1:0], nr_frac};
        endcase
    end

    // Output register: capture on launch, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            sum_out       <= '0;
            flg_invalid   <= 1'b0;
            flg_overflow  <= 1'b0;
            flg_underflow <= 1'b0;
            flg_inexact   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_out       <= nxt_word;
                flg_invalid   <= nxt_flags.invalid;
                flg_overflow  <= nxt_flags.overflow;
                flg_underflow <= nxt_flags.underflow;
                flg_inexact   <= nxt_flags.inexact;
            end
        end
    end

endmodule

// File: rtl/fp32_addsub_chk.sv
// Port-level temporal checks for the adder/subtractor, bound to every
// instance of the top module below.
module fp32_addsub_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] sum_out,
    input logic                  flg_invalid,
    input logic                  flg_overflow,
    input logic                  flg_underflow,
    input logic                  flg_inexact
);

    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    // R1
    launch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_out));

    // R8
    overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flg_overflow) |-> (sum_out[W-2:0] == INF_MAG) && flg_inexact);

    // R7
    underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flg_underflow) |-> (sum_out == '0) && flg_inexact);

    // R9
    invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flg_invalid) |-> (sum_out == QNAN));

    // R5
    zero_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (sum_out[W-2:0] == '0)) |-> !sum_out[W-1]);

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({flg_invalid, flg_overflow, flg_underflow}));

endmodule

bind fp32_addsub fp32_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .out_valid     (out_valid),
    .sum_out       (sum_out),
    .flg_invalid   (flg_invalid),
    .flg_overflow  (flg_overflow),
    .flg_underflow (flg_underflow),
    .flg_inexact   (flg_inexact)
);

// File: tb/sim_fp32_addsub.sv
// Self-checking bench: directed corners, a structured sweep over exponent
// gaps and fraction patterns, and random vectors against a real-number
// reference with its own round-to-nearest-even step.
module sim_fp32_addsub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        do_sub = 1'b0;
    logic        out_valid;
    logic [31:0] sum_out;
    logic        flg_invalid, flg_overflow, flg_underflow, flg_inexact;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;
    logic [31:0] rs = 32'h1234_5678;

    fp32_addsub u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .opnd_a (opnd_a), .opnd_b (opnd_b), .do_sub (do_sub),
        .out_valid (out_valid), .sum_out (sum_out),
        .flg_invalid (flg_invalid), .flg_overflow (flg_overflow),
        .flg_underflow (flg_underflow), .flg_inexact (flg_inexact)
    );

    always #2.5 clk = ~clk;

    // Watchdog: an over-long run counts as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual cycles %0d expected < 190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic real pow2(input int k);
        real v = 1.0;
        if (k >= 0) for (int j = 0; j < k; j++) v = v * 2.0;
        else        for (int j = 0; j < -k; j++) v = v / 2.0;
        return v;
    endfunction

    function automatic real decode(input logic [31:0] x);
        real v;
        if (x[30:23] == 8'd0) return 0.0;
        v = (1.0 + real'(x[22:0]) / 8388608.0) * pow2(int'(x[30:23]) - 127);
        return x[31] ? -v : v;
    endfunction

    // Reference model; flags = {invalid, overflow, underflow, inexact}
    task automatic ref_model(input logic [31:0] a, input logic [31:0] b, input logic s,
                             output logic [31:0] r, output logic [3:0] f);
        logic [31:0] bb;
        bit  nan_a, nan_b, inf_a, inf_b;
        real va, vb, sm, mag, x, fr;
        int  e, q;
        bb    = {b[31] ^ s, b[30:0]};
        nan_a = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        nan_b = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        inf_a = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        inf_b = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        f = 4'b0000;
        if (nan_a || nan_b) begin
            r = 32'h7FC0_0000;
            f[3] = (nan_a && !a[22]) || (nan_b && !b[22]);
        end else if (inf_a && inf_b && (a[31] != bb[31])) begin
            r = 32'h7FC0_0000; f[3] = 1'b1;
        end else if (inf_a) begin
            r = {a[31], 8'hFF, 23'd0};
        end else if (inf_b) begin
            r = {bb[31], 8'hFF, 23'd0};
        end else begin
            va = decode(a);
            vb = decode(bb);
            sm = va + vb;
            if (sm == 0.0) begin
                r = 32'd0;
            end else begin
                mag = (sm < 0.0) ? -sm : sm;
                if (mag < pow2(-126)) begin
                    r = 32'd0; f = 4'b0011;
                end else begin
                    e = 0;
                    while (mag >= 2.0) begin mag = mag / 2.0; e++; end
                    while (mag < 1.0)  begin mag = mag * 2.0; e--; end
                    x  = mag * 8388608.0;
                    q  = $rtoi(x);
                    fr = x - real'(q);
                    if (fr > 0.5 || (fr == 0.5 && q[0])) q++;
                    if (q == 32'h0100_0000) begin q = q / 2; e++; end
                    f[0] = (fr != 0.0);
                    // Sum not exact in double when gap is wide: always inexact then
                    if (va != 0.0 && vb != 0.0 &&
                        ((int'(a[30:23]) - int'(b[30:23]) >= 29) ||
                         (int'(b[30:23]) - int'(a[30:23]) >= 29)))
                        f[0] = 1'b1;
                    if (e > 127) begin
                        r = {sm < 0.0, 8'hFF, 23'd0}; f = 4'b0101;
                    end else begin
                        r = {sm < 0.0, 8'(e + 127), q[22:0]};
                    end
                end
            end
        end
    endtask

    // Launch one operation and compare the registered outcome one cycle later
    task automatic check_vec(input logic [31:0] a, input logic [31:0] b, input logic s,
                             input logic [31:0] er, input logic [3:0] ef, input string tag);
        logic [3:0] gf;
        opnd_a = a; opnd_b = b; do_sub = s; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        gf = {flg_invalid, flg_overflow, flg_underflow, flg_inexact};
        n_tests++;
        if (!out_valid || sum_out !== er || gf !== ef) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h sub=%0d actual %h/flags %b/v%0d expected %h/flags %b/v1",
                     tag, a, b, s, sum_out, gf, out_valid, er, ef);
        end
    endtask

    task automatic check_ref(input logic [31:0] a, input logic [31:0] b, input logic s,
                             input string tag);
        logic [31:0] er;
        logic [3:0]  ef;
        ref_model(a, b, s, er, ef);
        check_vec(a, b, s, er, ef, tag);
    endtask

    task automatic check_plain(input bit cond, input string tag, input logic [31:0] act,
                               input logic [31:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [22:0] pattern(input int k);
        case (k)
            0: return 23'h000000;
            1: return 23'h7FFFFF;
            2: return 23'h400000;
            3: return 23'h000001;
            4: return 23'h555555;
            5: return 23'h2AAAAA;
            6: return 23'h7FFFFE;
            default: return 23'h123456;
        endcase
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] v);
        logic [31:0] t = v;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_plain(out_valid == 1'b0 && sum_out == 32'd0 &&
                    {flg_invalid, flg_overflow, flg_underflow, flg_inexact} == 4'd0,
                    "R1 reset", sum_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 basic add and subtract
        check_vec(32'h3F80_0000, 32'h4000_0000, 1'b0, 32'h4040_0000, 4'b0000, "R2 1+2");
        check_vec(32'h4040_0000, 32'h3F80_0000, 1'b1, 32'h4000_0000, 4'b0000, "R2 3-1");
        // R3 alignment with lost bits and very wide gaps
        check_vec(32'h3F80_0000, 32'h33C0_0000, 1'b0, 32'h3F80_0001, 4'b0001, "R3 sticky up");
        check_vec(32'h7F00_0000, 32'h3F80_0000, 1'b0, 32'h7F00_0000, 4'b0001, "R3 gap 127");
        // R4 carry and rounding carry
        check_vec(32'h3FC0_0000, 32'h3FC0_0000, 1'b0, 32'h4040_0000, 4'b0000, "R4 carry");
        check_vec(32'h3F7F_FFFF, 32'h3300_0000, 1'b0, 32'h3F80_0000, 4'b0001, "R4 round carry");
        // R5 cancellation
        check_vec(32'h4049_0FDB, 32'h4049_0FDB, 1'b1, 32'h0000_0000, 4'b0000, "R5 x-x");
        check_vec(32'hC049_0FDB, 32'h4049_0FDB, 1'b0, 32'h0000_0000, 4'b0000, "R5 -x+x");
        check_vec(32'h3F80_0000, 32'h3F7F_FFFF, 1'b1, 32'h3380_0000, 4'b0000, "R5 lz shift");
        check_vec(32'h8080_0000, 32'h0080_0000, 1'b0, 32'h0000_0000, 4'b0000, "R5 min cancel");
        // R6 ties to even
        check_vec(32'h3F80_0000, 32'h3380_0000, 1'b0, 32'h3F80_0000, 4'b0001, "R6 tie down");
        check_vec(32'h3F80_0001, 32'h3380_0000, 1'b0, 32'h3F80_0002, 4'b0001, "R6 tie up");
        // R7 flush to zero
        check_vec(32'h0000_0001, 32'h3F80_0000, 1'b0, 32'h3F80_0000, 4'b0000, "R7 subnormal in");
        check_vec(32'h0040_0000, 32'h0040_0000, 1'b0, 32'h0000_0000, 4'b0000, "R7 both subnormal");
        check_vec(32'h0080_0001, 32'h0080_0000, 1'b1, 32'h0000_0000, 4'b0011, "R7 tiny result");
        // R8 overflow
        check_vec(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 32'h7F80_0000, 4'b0101, "R8 max+max");
        check_vec(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, 32'hFF80_0000, 4'b0101, "R8 neg");
        check_vec(32'h7F7F_FFFF, 32'h7300_0000, 1'b0, 32'h7F80_0000, 4'b0101, "R8 by rounding");
        // R9 invalid and NaN
        check_vec(32'h7F80_0000, 32'h7F80_0000, 1'b1, 32'h7FC0_0000, 4'b1000, "R9 inf-inf");
        check_vec(32'h7F80_0000, 32'hFF80_0000, 1'b0, 32'h7FC0_0000, 4'b1000, "R9 inf+-inf");
        check_vec(32'h7FC0_0001, 32'h3F80_0000, 1'b0, 32'h7FC0_0000, 4'b0000, "R9 quiet nan");
        check_vec(32'h3F80_0000, 32'h7F80_0001, 1'b0, 32'h7FC0_0000, 4'b1000, "R9 signalling nan");
        // R10 infinity propagation
        check_vec(32'h7F80_0000, 32'h3F80_0000, 1'b0, 32'h7F80_0000, 4'b0000, "R10 inf+1");
        check_vec(32'h3F80_0000, 32'h7F80_0000, 1'b1, 32'hFF80_0000, 4'b0000, "R10 1-inf");
        check_vec(32'hFF80_0000, 32'hFF80_0000, 1'b0, 32'hFF80_0000, 4'b0000, "R10 -inf-inf");
        // R11 inexact indication
        check_vec(32'h3F80_0000, 32'h3080_0000, 1'b0, 32'h3F80_0000, 4'b0001, "R11 1+tiny");
        check_vec(32'h3F80_0000, 32'h3080_0000, 1'b1, 32'h3F80_0000, 4'b0001, "R11 1-tiny");
        check_vec(32'h3F80_0000, 32'h3F80_0000, 1'b0, 32'h4000_0000, 4'b0000, "R11 exact");

        // R1 idle cycle: valid drops and result holds
        hold = sum_out;
        in_valid = 1'b0;
        opnd_a = 32'h4000_0000;
        @(posedge clk);
        @(negedge clk);
        check_plain(out_valid == 1'b0 && sum_out == hold, "R1 idle hold", sum_out, hold);

        // R2/R3 sweep over exponent gaps, fraction patterns, signs and operations
        for (int fa = 0; fa < 8; fa++)
            for (int fb = 0; fb < 8; fb++)
                for (int d = 0; d <= 40; d++)
                    for (int sg = 0; sg < 2; sg++)
                        for (int op = 0; op < 2; op++) begin
                            check_ref({1'b0, 8'd127, pattern(fa)},
                                      {sg[0], 8'(127 - d), pattern(fb)}, op[0], "R2/R3 sweep");
                            check_ref({sg[0], 8'(127 - d), pattern(fb)},
                                      {1'b0, 8'd127, pattern(fa)}, op[0], "R2/R3 sweep swapped");
                        end

        // R2/R11 random vectors, half of them near-cancelling pairs
        for (int n = 0; n < 20000; n++) begin
            logic [31:0] ra, rb, rc;
            rs = next_rand(rs); ra = rs;
            rs = next_rand(rs); rb = rs;
            rs = next_rand(rs); rc = rs;
            if (rc[0]) rb = {rc[1], ra[30:0]} ^ {24'd0, rb[7:0] & {8{rc[2]}}};
            check_ref(ra, rb, rc[3], "R2/R11 random");
        end

        in_valid = 1'b0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule